// File: doc/BRIEF.md
# Three-Wire Synchronous Serial Byte-Pair Receiver

This block receives a serial stream over a three-line link made of a frame-sync line, a link clock and a data line. It turns that stream into bytes and hands them to a processor in pairs. The data line uses NRZ-L coding, so the level sampled on each rising edge of the link clock is the bit value itself. A frame opens when the sync line gives a short high pulse and then drops low. It stays open while the sync line remains low.

Within an open frame, every eight link-clock rising edges make one byte, most significant bit first. Bytes are collected in pairs. The first byte of each pair goes to the high-byte register and the second goes to the low-byte register. When a pair is complete, a buffer-full interrupt is raised. The processor reads the pair through a small read port, and reading the low byte releases the buffer for the next pair.

All three link lines come from a foreign timing domain. Each one passes through its own synchronizer chain before its edges are detected on the system clock.

Top module: `tw_sync_rx`

## Requirements
- R1: After reset, `irq` and `overrun` are 0, and `rd_data` is 0 for both values of `rd_sel`.
- R2: Link-clock edges are ignored until the synchronized sync line has been high and has then fallen. Bits sent with no preceding sync pulse produce no interrupt and leave no partial byte or half pair behind.
- R3: Inside a frame, the data level at each link-clock rising edge is shifted in MSB first. A byte is complete after eight such edges.
- R4: The first byte of a pair is read with `rd_sel`=0 (high register). The second byte is read with `rd_sel`=1 (low register).
- R5: `irq` goes to 1 once both bytes of a pair have been stored.
- R6: A cycle with `rd_en`=1 and `rd_sel`=1 clears `irq`. A cycle with `rd_en`=1 and `rd_sel`=0 leaves `irq` unchanged.
- R7: After a read, further bytes in the same frame form the next pair, and that pair raises `irq` again.
- R8: If a new pair completes while `irq` is still 1, `overrun` is set and the stored pair is kept unchanged. A low-byte read clears `overrun` together with `irq`.
- R9: The sync line going high during a frame discards the partial byte, resets the bit count and drops any unpaired high byte. The next frame therefore starts with a fresh high byte.
- R10: Data, clock and sync all pass through chains of equal depth. A data change made at the same moment as the link-clock falling edge is therefore captured correctly, provided each link-clock level is held for at least `SYNC_STAGES`+1 system clocks.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_clk | input | 1 | Serial link clock, asynchronous |
| link_sync | input | 1 | Frame-sync line: a high pulse, then low for the frame |
| link_data | input | 1 | NRZ-L serial data |
| rd_en | input | 1 | Read strobe from the processor |
| rd_sel | input | 1 | 0 selects the high byte, 1 selects the low byte |
| rd_data | output | BYTE_W | Selected byte of the stored pair |
| irq | output | 1 | Buffer-full interrupt |
| overrun | output | 1 | A pair was lost because the buffer was still full |

## Verification
The bench builds the block with its default parameters: BYTE_W=8 and SYNC_STAGES=2. With these values, one byte of link traffic takes only about 64 system clocks. This makes it practical to run back-to-back pairs, a deliberately unread buffer that provokes an overrun, and frames aborted in the middle of a byte or after a lone high byte. The two-stage chains also make it possible to drive a tight link clock, held three system clocks per level with data switching on its falling edge. This tests the alignment of the sampled data across the synchronizers.

// File: rtl/tw_rx_pkg.sv
package tw_rx_pkg;
    typedef enum logic {
        SEL_HI = 1'b0,
        SEL_LO = 1'b1
    } rd_sel_e;
endpackage

// File: rtl/tw_rx_sync.sv
module tw_rx_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    assign chain_d[0] = din;
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        assign chain_d[g] = chain_q[g-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/tw_rx_shift.sv
module tw_rx_shift #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lclk_s,
    input  logic              sync_s,
    input  logic              data_s,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_out,
    output logic [CNT_W-1:0]  bit_cnt
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        logic              lclk_prev;
        logic              sync_prev;
        logic              in_frame;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] shreg;
        logic              vld;
        logic [BYTE_W-1:0] data;
    } shift_t;

    shift_t st_d, st_q;
    logic [BYTE_W-1:0] shifted;

    assign shifted = {st_q.shreg[BYTE_W-2:0], data_s};

    always_comb begin
        st_d           = st_q;
        st_d.vld       = 1'b0;
        st_d.lclk_prev = lclk_s;
        st_d.sync_prev = sync_s;
        if (sync_s) begin
            st_d.in_frame = 1'b0;
            st_d.cnt      = '0;
        end else if (st_q.sync_prev) begin
            st_d.in_frame = 1'b1;
            st_d.cnt      = '0;
        end else if (st_q.in_frame && lclk_s && !st_q.lclk_prev) begin
            st_d.shreg = shifted;
            if (st_q.cnt == LAST) begin
                st_d.cnt  = '0;
                st_d.vld  = 1'b1;
                st_d.data = shifted;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign byte_vld = st_q.vld;
    assign byte_out = st_q.data;
    assign bit_cnt  = st_q.cnt;
endmodule

// File: rtl/tw_rx_pair.sv
module tw_rx_pair
    import tw_rx_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              frame_drop,
    input  logic              rd_en,
    input  logic              rd_sel,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] hi_byte,
    output logic [BYTE_W-1:0] lo_byte,
    output logic              full,
    output logic              ovr
);
    typedef struct packed {
        logic [BYTE_W-1:0] stage;
        logic              have_hi;
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
        logic              full;
        logic              ovr;
    } pair_t;

    pair_t pr_d, pr_q;
    logic  rd_lo;

    assign rd_lo = rd_en && (rd_sel_e'(rd_sel) == SEL_LO);

    always_comb begin
        pr_d = pr_q;
        if (rd_lo) begin
            pr_d.full = 1'b0;
            pr_d.ovr  = 1'b0;
        end
        if (byte_vld) begin
            if (!pr_q.have_hi) begin
                pr_d.stage   = byte_in;
                pr_d.have_hi = 1'b1;
            end else begin
                pr_d.have_hi = 1'b0;
                if (pr_d.full) begin
                    pr_d.ovr = 1'b1;
                end else begin
                    pr_d.hi   = pr_q.stage;
                    pr_d.lo   = byte_in;
                    pr_d.full = 1'b1;
                end
            end
        end
        if (frame_drop) pr_d.have_hi = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pr_q <= '0;
        else        pr_q <= pr_d;
    end

    assign rd_data = (rd_sel_e'(rd_sel) == SEL_LO) ? pr_q.lo : pr_q.hi;
    assign hi_byte = pr_q.hi;
    assign lo_byte = pr_q.lo;
    assign full    = pr_q.full;
    assign ovr     = pr_q.ovr;
endmodule

// File: rtl/tw_sync_rx.sv
module tw_sync_rx #(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = (BYTE_W > 1) ? $clog2(BYTE_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_clk,
    input  logic              link_sync,
    input  logic              link_data,
    input  logic              rd_en,
    input  logic              rd_sel,
    output logic [BYTE_W-1:0] rd_data,
    output logic              irq,
    output logic              overrun
);
    logic              lclk_s, sync_s, data_s;
    logic              byte_vld;
    logic [BYTE_W-1:0] byte_val;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] hi_byte, lo_byte;

    tw_rx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({link_clk, link_sync, link_data}),
        .dout ({lclk_s, sync_s, data_s})
    );

    tw_rx_shift #(.BYTE_W(BYTE_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .lclk_s  (lclk_s),
        .sync_s  (sync_s),
        .data_s  (data_s),
        .byte_vld(byte_vld),
        .byte_out(byte_val),
        .bit_cnt (bit_cnt)
    );

    tw_rx_pair #(.BYTE_W(BYTE_W)) u_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_vld  (byte_vld),
        .byte_in   (byte_val),
        .frame_drop(sync_s),
        .rd_en     (rd_en),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data),
        .hi_byte   (hi_byte),
        .lo_byte   (lo_byte),
        .full      (irq),
        .ovr       (overrun)
    );
endmodule

// File: rtl/tw_sync_rx_chk.sv
module tw_sync_rx_chk #(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sync_s,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic              byte_vld,
    input logic              rd_en,
    input logic              rd_sel,
    input logic              irq,
    input logic              overrun,
    input logic [BYTE_W-1:0] hi_byte,
    input logic [BYTE_W-1:0] lo_byte
);
    // R5
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(byte_vld));

    // R6
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(rd_en && rd_sel));

    // R8
    keep_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(rd_en && rd_sel)) |=> ($stable(hi_byte) && $stable(lo_byte)));

    // R8
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(irq));

    // R9
    abort_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_s |=> (bit_cnt == '0));
endmodule

bind tw_sync_rx tw_sync_rx_chk #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_s  (sync_s),
    .bit_cnt (bit_cnt),
    .byte_vld(byte_vld),
    .rd_en   (rd_en),
    .rd_sel  (rd_sel),
    .irq     (irq),
    .overrun (overrun),
    .hi_byte (hi_byte),
    .lo_byte (lo_byte)
);

// File: tb/sim_tw_sync_rx.sv
`timescale 1ns/1ps
module sim_tw_sync_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       link_clk = 1'b0;
    logic       link_sync = 1'b0;
    logic       link_data = 1'b0;
    logic       rd_en = 1'b0;
    logic       rd_sel = 1'b0;
    logic [7:0] rd_data;
    logic       irq, overrun;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    tw_sync_rx u0 (
        .clk(clk), .rst_n(rst_n), .link_clk(link_clk), .link_sync(link_sync),
        .link_data(link_data), .rd_en(rd_en), .rd_sel(rd_sel),
        .rd_data(rd_data), .irq(irq), .overrun(overrun)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            link_data = b[i];
            tick(4);
            link_clk = 1'b1;
            tick(4);
            link_clk = 1'b0;
        end
        tick(2);
    endtask

    task automatic send_tight(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            link_clk  = 1'b0;
            link_data = b[i];
            tick(3);
            link_clk = 1'b1;
            tick(3);
        end
        link_clk = 1'b0;
        tick(3);
    endtask

    task automatic start_frame();
        link_sync = 1'b1;
        tick(4);
        link_sync = 1'b0;
        tick(4);
    endtask

    task automatic end_frame();
        link_sync = 1'b1;
        tick(6);
    endtask

    task automatic read_byte(input logic sel);
        rd_sel = sel;
        rd_en  = 1'b1;
        tick(1);
        rd_en  = 1'b0;
        tick(1);
    endtask

    task automatic expect_pair(input string req, input logic [7:0] h, input logic [7:0] l);
        tick(8);
        check({req, " irq"}, int'(irq), 1);
        rd_sel = 1'b0; #1;
        check({req, " high byte"}, int'(rd_data), int'(h));
        rd_sel = 1'b1; #1;
        check({req, " low byte"}, int'(rd_data), int'(l));
    endtask

    task automatic t_reset();
        rd_sel = 1'b0; #1;
        check("R1 irq", int'(irq), 0);
        check("R1 overrun", int'(overrun), 0);
        check("R1 hi", int'(rd_data), 0);
        rd_sel = 1'b1; #1;
        check("R1 lo", int'(rd_data), 0);
    endtask

    task automatic t_no_sync();
        send_byte(8'hFF);
        send_byte(8'h0F);
        send_byte(8'hF0);
        tick(8);
        check("R2 no irq without sync", int'(irq), 0);
        start_frame();
        send_byte(8'hA5);
        send_byte(8'h3C);
        expect_pair("R2 R3 R4 R5", 8'hA5, 8'h3C);
    endtask

    task automatic t_read();
        read_byte(1'b0);
        check("R6 high read keeps irq", int'(irq), 1);
        read_byte(1'b1);
        check("R6 low read clears irq", int'(irq), 0);
    endtask

    task automatic t_next_pair();
        send_byte(8'h81);
        send_byte(8'h7E);
        expect_pair("R7", 8'h81, 8'h7E);
        read_byte(1'b1);
        check("R7 cleared", int'(irq), 0);
    endtask

    task automatic t_overrun();
        send_byte(8'h11);
        send_byte(8'h22);
        tick(8);
        check("R8 no overrun yet", int'(overrun), 0);
        send_byte(8'h33);
        send_byte(8'h44);
        tick(8);
        check("R8 overrun set", int'(overrun), 1);
        expect_pair("R8 old pair kept", 8'h11, 8'h22);
        read_byte(1'b1);
        check("R8 overrun cleared", int'(overrun), 0);
        check("R8 irq cleared", int'(irq), 0);
    endtask

    task automatic t_abort();
        end_frame();
        start_frame();
        send_byte(8'h99);
        link_data = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick(4); link_clk = 1'b1; tick(4); link_clk = 1'b0;
        end
        end_frame();
        start_frame();
        send_byte(8'hC3);
        send_byte(8'h5A);
        expect_pair("R9 partial and half pair dropped", 8'hC3, 8'h5A);
        read_byte(1'b1);
    endtask

    task automatic t_tight();
        send_tight(8'h96);
        send_tight(8'h6B);
        expect_pair("R10 tight clock", 8'h96, 8'h6B);
        read_byte(1'b1);
    endtask

    initial begin
        fork
            begin
                tick(4);
                rst_n = 1'b1;
                tick(2);
                t_reset();
                t_no_sync();
                t_read();
                t_next_pair();
                t_overrun();
                t_abort();
                t_tight();
            end
            begin
                repeat (150000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule